// File: doc/BRIEF.md
# Trigger FIFO Occupancy Emulator with Veto

This block keeps a running estimate of how full the 32-sample trigger FIFO inside a front-end readout chip is. The chip cannot report its fill level, so the estimate is built from timing alone. Each accepted trigger adds either 3 or 6 samples, depending on the sample mode of that trigger. One sample leaves the FIFO every 140 clock cycles while the FIFO holds anything. When the estimate reaches a programmable threshold, the block raises a veto so that the trigger logic stops issuing triggers before the real FIFO can overflow.

The block sits next to the global trigger decision and runs on the 32 MHz system clock. A trigger that arrives while the veto is high is not counted and sets a sticky reject flag. Receiving a trigger occupies the chip for as many clocks as the trigger has samples. A second trigger inside that busy window sets a sticky spacing flag. The emulated occupancy is also brought out as a count.

Top module: `trig_fifo_veto`

## Requirements
- R1: The occupancy count never exceeds 32 and never goes below 0. An increment that would pass 32 saturates at 32.
- R2: A trigger accepted while `mode6_i` is 0 adds 3 samples. A trigger accepted while `mode6_i` is 1 adds 6 samples. The new count is visible after the clock edge that samples the trigger.
- R3: While the occupancy is nonzero, it drops by one every 140 cycles. The slot timer restarts whenever the occupancy leaves 0, so the first drop comes 140 edges after the edge that made the count nonzero.
- R4: `veto_o` is high exactly when the occupancy is greater than or equal to `thresh_i`. It falls in the same cycle in which the occupancy drops below `thresh_i`. A threshold above 32 never vetoes.
- R5: A trigger that arrives while `veto_o` is high leaves the occupancy unchanged apart from any drain, and it sets `reject_err_o`. This flag stays high until reset.
- R6: When a trigger is accepted in the same cycle as a drain, both take effect. For example, 3 + 3 - 1 gives 5.
- R7: A trigger sampled 1 or 2 edges after a 3-sample trigger, or 1 to 5 edges after a 6-sample trigger, sets `spacing_err_o`, which stays high until reset. Triggers spaced by at least the sample count do not set it. A violating trigger is still counted if it is not vetoed.
- R8: An asynchronous active-low reset clears the occupancy, the slot timer and both flags. Release is synchronised to the clock through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Single-cycle trigger pulse |
| mode6_i | input | 1 | Sample mode of this trigger: 0 means 3 samples, 1 means 6 samples |
| thresh_i | input | 6 | Veto threshold in samples |
| veto_o | output | 1 | Trigger veto |
| occ_o | output | 6 | Emulated FIFO occupancy |
| reject_err_o | output | 1 | Sticky flag: a trigger arrived while vetoed |
| spacing_err_o | output | 1 | Sticky flag: a trigger arrived inside the previous trigger's busy window |

## Verification
The bound checker watches several rules on every cycle:
- the count stays within its bound;
- an accepted trigger always raises the count unless it is already saturated;
- a vetoed trigger never raises the count;
- without a trigger, the count moves by at most one step down;
- an empty FIFO stays empty;
- both error flags are sticky.

Other behaviours depend on exact cycle positions or on a long history, and only the directed scenarios show them:
- the 140-cycle drain spacing;
- the timer restart after the count leaves 0;
- the exact sum when a trigger and a drain coincide;
- the boundaries of the spacing window;
- the veto falling exactly as the count crosses the threshold.

// File: rtl/fifo_emu_pkg.sv
package fifo_emu_pkg;
  // sample mode carried with each trigger
  typedef enum logic {
    SMP_SHORT = 1'b0,
    SMP_LONG  = 1'b1
  } smp_mode_e;
endpackage

// File: rtl/drain_timer.sv
module drain_timer #(
  parameter int SLOT_CYC = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic tick_o
);
  localparam int TW = $clog2(SLOT_CYC);
  localparam logic [TW-1:0] LAST = TW'(SLOT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // tick on the final cycle of each readout slot
  assign tick_o = active_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b1;
    if (!active_i)    cnt_d = '0;
    else if (tick_o)  cnt_d = '0;
    else              cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/occ_tracker.sv
module occ_tracker #(
  parameter int DEPTH   = 32,
  parameter int N_SHORT = 3,
  parameter int N_LONG  = 6,
  parameter int OCC_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en_i,
  input  fifo_emu_pkg::smp_mode_e mode_i,
  input  logic             drain_i,
  output logic [OCC_W-1:0] occ_o
);
  import fifo_emu_pkg::*;
  localparam int SW = OCC_W + 1;
  localparam logic [SW-1:0] LIMIT = SW'(DEPTH);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic [SW-1:0]    add_amt, sum;
  logic             occ_en;

  always_comb begin
    occ_en  = add_en_i || drain_i;
    add_amt = '0;
    if (add_en_i) add_amt = (mode_i == SMP_LONG) ? SW'(N_LONG) : SW'(N_SHORT);
    // drain is only asserted when occupancy is nonzero, so no underflow
    sum = {1'b0, occ_q} + add_amt - SW'(drain_i);
    if (sum > LIMIT) occ_d = OCC_W'(DEPTH);
    else             occ_d = sum[OCC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/spacing_guard.sv
module spacing_guard #(
  parameter int N_SHORT = 3,
  parameter int N_LONG  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  fifo_emu_pkg::smp_mode_e mode_i,
  output logic viol_o
);
  import fifo_emu_pkg::*;
  localparam int CW = $clog2(N_LONG);

  logic [CW-1:0] busy_q, busy_d;
  logic          busy_en;

  // a trigger while the receive window is still open is a violation
  assign viol_o = trig_i && (busy_q != '0);

  always_comb begin
    busy_en = 1'b1;
    busy_d  = busy_q;
    if (trig_i && busy_q == '0)
      busy_d = (mode_i == SMP_LONG) ? CW'(N_LONG - 1) : CW'(N_SHORT - 1);
    else if (busy_q != '0)
      busy_d = busy_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end
endmodule

// File: rtl/trig_fifo_veto.sv
module trig_fifo_veto #(
  parameter int DEPTH    = 32,
  parameter int SLOT_CYC = 140,
  parameter int N_SHORT  = 3,
  parameter int N_LONG   = 6,
  parameter int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             mode6_i,
  input  logic [OCC_W-1:0] thresh_i,
  output logic             veto_o,
  output logic [OCC_W-1:0] occ_o,
  output logic             reject_err_o,
  output logic             spacing_err_o
);
  import fifo_emu_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  smp_mode_e  mode;
  logic       accept, drain, viol;
  logic [OCC_W-1:0] occ;
  logic       rej_q, rej_d, spc_q, spc_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign mode   = smp_mode_e'(mode6_i);
  assign veto_o = (occ >= thresh_i);
  assign accept = trig_i && !veto_o;

  drain_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .active_i(occ != '0), .tick_o(drain)
  );

  occ_tracker #(.DEPTH(DEPTH), .N_SHORT(N_SHORT), .N_LONG(N_LONG), .OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst_n(rst_n_int), .add_en_i(accept), .mode_i(mode),
    .drain_i(drain), .occ_o(occ)
  );

  spacing_guard #(.N_SHORT(N_SHORT), .N_LONG(N_LONG)) u_space (
    .clk(clk), .rst_n(rst_n_int), .trig_i(trig_i), .mode_i(mode), .viol_o(viol)
  );

  always_comb begin
    rej_d = rej_q || (trig_i && veto_o);
    spc_d = spc_q || viol;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rej_q <= 1'b0;
      spc_q <= 1'b0;
    end else begin
      rej_q <= rej_d;
      spc_q <= spc_d;
    end
  end

  assign occ_o         = occ;
  assign reject_err_o  = rej_q;
  assign spacing_err_o = spc_q;
endmodule

// File: rtl/trig_fifo_veto_chk.sv
module trig_fifo_veto_chk #(
  parameter int DEPTH = 32,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             veto_o,
  input logic [OCC_W-1:0] occ_o,
  input logic             reject_err_o,
  input logic             spacing_err_o
);
  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o <= OCC_W'(DEPTH));

  // R2
  accept_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !veto_o) |=> (occ_o > $past(occ_o)) || (occ_o == OCC_W'(DEPTH)));

  // R5
  vetoed_no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && veto_o) |=> occ_o <= $past(occ_o));

  // R3
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> (occ_o == $past(occ_o)) || (occ_o + OCC_W'(1) == $past(occ_o)));

  // R1
  empty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_o == '0 && !trig_i) |=> occ_o == '0);

  // R5
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_err_o |=> reject_err_o);

  // R7
  spacing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err_o |=> spacing_err_o);
endmodule

bind trig_fifo_veto trig_fifo_veto_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .veto_o(veto_o), .occ_o(occ_o),
  .reject_err_o(reject_err_o), .spacing_err_o(spacing_err_o)
);

// File: tb/tb_trig_fifo_veto.sv
module tb_trig_fifo_veto;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_i, mode6_i;
  logic [5:0] thresh_i;
  logic       veto_o, reject_err_o, spacing_err_o;
  logic [5:0] occ_o;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  trig_fifo_veto dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode6_i(mode6_i),
    .thresh_i(thresh_i), .veto_o(veto_o), .occ_o(occ_o),
    .reject_err_o(reject_err_o), .spacing_err_o(spacing_err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic m6);
    trig_i = 1'b1; mode6_i = m6;
    @(posedge clk);
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic do_reset(input logic [5:0] thr);
    @(negedge clk);
    rst_n = 1'b0; trig_i = 1'b0; mode6_i = 1'b0; thresh_i = thr;
    gap(2);
    rst_n = 1'b1;
    gap(3);
  endtask

  task automatic t_reset();
    do_reset(6'd26);
    check(occ_o == 0, "R8 occ after reset", occ_o, 0);
    check(veto_o == 0, "R8 veto after reset", veto_o, 0);
    check(reject_err_o == 0 && spacing_err_o == 0, "R8 flags after reset",
          {reject_err_o, spacing_err_o}, 0);
  endtask

  task automatic t_add();
    do_reset(6'd63);
    pulse(1'b0);
    check(occ_o == 3, "R2 short trigger adds 3", occ_o, 3);
    gap(2);
    pulse(1'b1);
    check(occ_o == 9, "R2 long trigger adds 6", occ_o, 9);
  endtask

  task automatic t_drain();
    do_reset(6'd63);
    pulse(1'b0);
    gap(139);
    check(occ_o == 3, "R3 no drain before 140 cycles", occ_o, 3);
    gap(1);
    check(occ_o == 2, "R3 first drain at 140", occ_o, 2);
    gap(140);
    check(occ_o == 1, "R3 second drain", occ_o, 1);
  endtask

  task automatic t_coincide();
    do_reset(6'd63);
    pulse(1'b0);
    gap(139);
    pulse(1'b0);
    check(occ_o == 5, "R6 add and drain same cycle", occ_o, 5);
  endtask

  task automatic t_veto();
    int n;
    do_reset(6'd26);
    for (int i = 0; i < 4; i++) begin pulse(1'b1); gap(5); end
    check(occ_o == 24 && veto_o == 0, "R4 below threshold no veto", occ_o, 24);
    pulse(1'b1);
    check(occ_o == 30 && veto_o == 1, "R4 veto at threshold", {veto_o, occ_o}, 64 + 30);
    gap(5);
    pulse(1'b1);
    check(occ_o == 30, "R5 vetoed trigger not counted", occ_o, 30);
    check(reject_err_o == 1, "R5 reject flag set", reject_err_o, 1);
    n = 0;
    while (occ_o != 26 && n < 2000) begin gap(1); n++; end
    check(veto_o == 1, "R4 veto held at 26", veto_o, 1);
    n = 0;
    while (occ_o != 25 && n < 2000) begin gap(1); n++; end
    check(veto_o == 0, "R4 veto drops below threshold", veto_o, 0);
    check(reject_err_o == 1, "R5 reject flag sticky", reject_err_o, 1);
    n = 0;
    while (occ_o != 0 && n < 6000) begin gap(1); n++; end
    gap(300);
    check(occ_o == 0, "R1 occupancy floors at 0", occ_o, 0);
    pulse(1'b0);
    gap(139);
    check(occ_o == 3, "R3 timer restarted from empty", occ_o, 3);
    gap(1);
    check(occ_o == 2, "R3 drain 140 after restart", occ_o, 2);
  endtask

  task automatic t_saturate();
    do_reset(6'd63);
    for (int i = 0; i < 6; i++) begin pulse(1'b1); gap(5); end
    check(occ_o == 32, "R1 saturates at 32", occ_o, 32);
    check(veto_o == 0, "R4 threshold above depth never vetoes", veto_o, 0);
  endtask

  task automatic t_thresh();
    do_reset(6'd4);
    pulse(1'b0);
    check(veto_o == 0, "R4 programmed 4, occ 3", veto_o, 0);
    gap(2);
    pulse(1'b0);
    check(veto_o == 1 && occ_o == 6, "R4 programmed 4, occ 6", occ_o, 6);
  endtask

  task automatic t_spacing();
    do_reset(6'd63);
    pulse(1'b0); gap(2); pulse(1'b0);
    check(spacing_err_o == 0, "R7 short spacing 3 ok", spacing_err_o, 0);
    do_reset(6'd63);
    pulse(1'b0); gap(1); pulse(1'b0);
    check(spacing_err_o == 1, "R7 short spacing 2 flagged", spacing_err_o, 1);
    check(occ_o == 6, "R7 violating trigger still counted", occ_o, 6);
    do_reset(6'd63);
    pulse(1'b1); gap(5); pulse(1'b1);
    check(spacing_err_o == 0, "R7 long spacing 6 ok", spacing_err_o, 0);
    do_reset(6'd63);
    pulse(1'b1); gap(4); pulse(1'b1);
    check(spacing_err_o == 1, "R7 long spacing 5 flagged", spacing_err_o, 1);
    gap(20);
    check(spacing_err_o == 1, "R7 flag sticky", spacing_err_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_i = 1'b0; mode6_i = 1'b0; thresh_i = 6'd26;
    t_reset();
    t_add();
    t_drain();
    t_coincide();
    t_veto();
    t_saturate();
    t_thresh();
    t_spacing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule